// File: doc/BRIEF.md
# Adaptive Idle-Limit Predictor

This block supplies the idle-cycle limit used by a page closer. That closer shuts an open DRAM page after the limit has expired. The block watches three single-cycle event strobes from the access path: a page hit, a page miss and a page conflict. While it is turned on, it keeps a learned limit that starts at a configured base value and tracks the workload. A miss means the page was closed too soon, so the limit rises by one step. A conflict means the page stayed open too long, so the limit falls by one step. A hit needs no change.

While it is turned off, the output simply follows the configured base value. Any change to the base value, or any period with the block turned off, throws away what was learned. The learned value then restarts from the base.

All inputs are plain control levels or strobes sampled on the rising clock edge. There is no streaming data path, so there is no valid/ready handshake and no back-pressure. The output is a level that the page closer may sample in any cycle.

Top module: `idle_limit_predictor`

## Requirements
- R1: While `enable` is high and `base_limit` has been stable since the previous clock edge, the limit first presented after enabling equals `base_limit`.
- R2: With the block enabled, a cycle in which `miss` is high and `conflict` is low raises the limit by 4 at the next clock edge.
- R3: With the block enabled, a cycle in which `conflict` is high and `miss` is low lowers the limit by 4 at the next clock edge.
- R4: While `enable` is low, `limit` equals `base_limit` in the same cycle. Event strobes have no effect on it.
- R5: A cycle with only `hit` high, or with no strobe high, leaves the limit unchanged.
- R6: A cycle with `miss` and `conflict` both high leaves the limit unchanged.
- R7: The limit saturates. It never rises above 127 and never falls below 0; a step that would cross a bound stops at that bound.
- R8: When `base_limit` differs from its value at the previous edge, the limit becomes the new base at the next edge, and strobes in that cycle are ignored. Dropping `enable` and raising it again also restarts the limit from `base_limit`. During the cycle in which the base changes, the old limit is still shown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | 1 = adaptive tuning, 0 = pass the base value through |
| base_limit | input | 7 | Configured starting limit in cycles |
| hit | input | 1 | Page hit strobe, one cycle per event |
| miss | input | 1 | Page miss strobe, one cycle per event |
| conflict | input | 1 | Page conflict strobe, one cycle per event |
| limit | output | 7 | Idle-cycle limit handed to the page closer |

## Verification
The tuning function is driven with runs of misses, runs of conflicts, hit-only cycles and cycles where miss and conflict coincide. These runs show the up step, the down step and the two hold cases apart. Runs that start near 127 and near 0 show that saturation clips at the bound instead of wrapping. A base change arriving together with a miss shows that the reload wins over the event and that the old value is held for one cycle. An enable drop in the middle of a run shows the pass-through behaviour and the restart from the base.

// File: rtl/idle_pred_pkg.sv
package idle_pred_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'b00,
    STEP_UP   = 2'b01,
    STEP_DOWN = 2'b10
  } step_e;
endpackage

// File: rtl/idle_evt_decode.sv
module idle_evt_decode
  import idle_pred_pkg::*;
(
  input  logic  miss_i,
  input  logic  conflict_i,
  output step_e dir_o
);
  // A lone miss asks for a longer window and a lone conflict for a shorter one.
  // When both arrive together they cancel.
  always_comb begin
    if (miss_i && !conflict_i)      dir_o = STEP_UP;
    else if (conflict_i && !miss_i) dir_o = STEP_DOWN;
    else                            dir_o = STEP_HOLD;
  end
endmodule

// File: rtl/idle_sat_step.sv
module idle_sat_step
  import idle_pred_pkg::*;
#(
  parameter int W    = 7,
  parameter int STEP = 4
) (
  input  logic [W-1:0] cur_i,
  input  step_e        dir_i,
  output logic [W-1:0] nxt_o
);
  localparam logic [W:0]   MAXV   = {1'b0, {W{1'b1}}};
  localparam logic [W:0]   STEP_W = (W+1)'(STEP);
  localparam logic [W-1:0] STEP_N = W'(STEP);

  logic [W:0]   up_wide;
  logic [W-1:0] up_sat;
  logic [W-1:0] dn_sat;

  always_comb begin
    up_wide = {1'b0, cur_i} + STEP_W;
    up_sat  = (up_wide > MAXV) ? MAXV[W-1:0] : up_wide[W-1:0];
    dn_sat  = (cur_i < STEP_N) ? '0 : cur_i - STEP_N;
    unique case (dir_i)
      STEP_UP:   nxt_o = up_sat;
      STEP_DOWN: nxt_o = dn_sat;
      default:   nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/idle_reload_ctl.sv
module idle_reload_ctl #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable_i,
  input  logic [W-1:0] base_i,
  output logic         reload_o,
  output logic         primed_o
);
  logic [W-1:0] base_q;
  logic         primed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      base_q   <= base_i;
      primed_q <= 1'b1;
    end
  end

  // Reload while off, on the first cycle after reset, and whenever the base moves.
  assign reload_o = !enable_i || !primed_q || (base_i != base_q);
  assign primed_o = primed_q;

  a_r8_base_move_reloads: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && base_i != $past(base_i)) |-> reload_o);
endmodule

// File: rtl/idle_limit_predictor.sv
module idle_limit_predictor
  import idle_pred_pkg::*;
#(
  parameter int LIMIT_W = 7,
  parameter int STEP    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [LIMIT_W-1:0] base_limit,
  input  logic               hit,
  input  logic               miss,
  input  logic               conflict,
  output logic [LIMIT_W-1:0] limit
);
  localparam logic [LIMIT_W-1:0] LIM_MAX = {LIMIT_W{1'b1}};

  step_e              dir;
  logic [LIMIT_W-1:0] cur_q;
  logic [LIMIT_W-1:0] stepped;
  logic               reload;
  logic               primed;

  idle_evt_decode u_dec (
    .miss_i     (miss),
    .conflict_i (conflict),
    .dir_o      (dir)
  );

  idle_sat_step #(.W(LIMIT_W), .STEP(STEP)) u_step (
    .cur_i (cur_q),
    .dir_i (dir),
    .nxt_o (stepped)
  );

  idle_reload_ctl #(.W(LIMIT_W)) u_rld (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable_i (enable),
    .base_i   (base_limit),
    .reload_o (reload),
    .primed_o (primed)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      cur_q <= '0;
    else if (reload) cur_q <= base_limit;
    else             cur_q <= stepped;
  end

  assign limit = (enable && primed) ? cur_q : base_limit;

  a_r2_miss_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && miss && !conflict && cur_q != LIM_MAX) |=> (cur_q > $past(cur_q)));
  a_r3_conflict_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && conflict && !miss && cur_q != '0) |=> (cur_q < $past(cur_q)));
  a_r5_hit_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && !miss && !conflict) |=> $stable(cur_q));
  a_r5_hit_only_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && hit && !miss && !conflict) |=> $stable(cur_q));
  a_r6_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && miss && conflict) |=> $stable(cur_q));
  a_r8_reload_takes_base: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (cur_q == $past(base_limit)));
endmodule

// File: tb/idle_limit_predictor_test.sv
module idle_limit_predictor_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [6:0] base_limit = 7'd20;
  logic       hit = 1'b0;
  logic       miss = 1'b0;
  logic       conflict = 1'b0;
  logic [6:0] limit;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  idle_limit_predictor uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .base_limit(base_limit),
    .hit(hit), .miss(miss), .conflict(conflict), .limit(limit)
  );

  task automatic chk(input string req, input logic [6:0] exp);
    checks++;
    if (limit !== exp) begin
      errors++;
      $display("FAIL %s: limit=%0d expected=%0d", req, limit, exp);
    end
  endtask

  // Called at a falling edge: drive the strobes, let one rising edge pass,
  // then return at the next falling edge with the strobes cleared.
  task automatic pulse(input logic h, input logic m, input logic c);
    hit = h; miss = m; conflict = c;
    @(negedge clk);
    hit = 1'b0; miss = 1'b0; conflict = 1'b0;
  endtask

  task automatic t_reset_and_start();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R4 reset passthru", 7'd20);
    @(negedge clk);
    enable = 1'b1; base_limit = 7'd40;
    @(negedge clk);
    chk("R1 start from base", 7'd40);
  endtask

  task automatic t_steps();
    pulse(0, 1, 0); chk("R2 miss up", 7'd44);
    pulse(0, 1, 0); chk("R2 miss up again", 7'd48);
    pulse(0, 0, 1); chk("R3 conflict down", 7'd44);
    pulse(1, 0, 0); chk("R5 hit holds", 7'd44);
    pulse(0, 0, 0); chk("R5 idle holds", 7'd44);
    pulse(0, 1, 1); chk("R6 both hold", 7'd44);
    pulse(1, 1, 1); chk("R6 all strobes hold", 7'd44);
  endtask

  task automatic t_saturate();
    base_limit = 7'd120; @(negedge clk);
    chk("R8 base reload high", 7'd120);
    pulse(0, 1, 0); chk("R7 up to 124", 7'd124);
    pulse(0, 1, 0); chk("R7 clip at 127", 7'd127);
    pulse(0, 1, 0); chk("R7 stays 127", 7'd127);
    base_limit = 7'd6; @(negedge clk);
    chk("R8 base reload low", 7'd6);
    pulse(0, 0, 1); chk("R7 down to 2", 7'd2);
    pulse(0, 0, 1); chk("R7 clip at 0", 7'd0);
    pulse(0, 0, 1); chk("R7 stays 0", 7'd0);
  endtask

  task automatic t_reload();
    base_limit = 7'd60; miss = 1'b1;
    #1 chk("R8 old value shown in change cycle", 7'd0);
    @(negedge clk); miss = 1'b0;
    chk("R8 reload beats miss", 7'd60);
    pulse(0, 1, 0); chk("R2 miss after reload", 7'd64);
    enable = 1'b0;
    #1 chk("R4 passthru when off", 7'd60);
    @(negedge clk);
    pulse(0, 1, 0); chk("R4 miss ignored when off", 7'd60);
    pulse(0, 0, 1); chk("R4 conflict ignored when off", 7'd60);
    base_limit = 7'd33;
    #1 chk("R4 base followed at once", 7'd33);
    @(negedge clk);
    enable = 1'b1;
    #1 chk("R8 restart from base on enable", 7'd33);
    @(negedge clk);
    pulse(0, 0, 1); chk("R3 conflict after restart", 7'd29);
  endtask

  initial begin
    t_reset_and_start();
    t_steps();
    t_saturate();
    t_reload();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(100000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule